// File: doc/BRIEF.md
# Lockable Thermal-Trip Register Bank

This block holds the configuration of an on-die thermal monitor and produces its shutdown request. Firmware programs an 8-bit critical temperature threshold, a 32-bit calibration slope and a shutdown-enable control through a simple 32-bit register port. It then sets a sticky lock. From that point on, software cannot change any of those three settings, including the enable that decides whether an over-temperature event requests shutdown.

Each cycle the block samples an already-converted 8-bit temperature. It raises its shutdown request while shutdown is enabled and the sampled temperature is at or above the threshold. Reads return the register contents one cycle after the read strobe. Writes to read-only, locked or unmapped locations complete silently and change nothing. The lock can be cleared only by asserting the hardware reset input.

Register word addresses:

| Address | Register |
|---|---|
| 0 | threshold |
| 1 | slope |
| 2 | shutdown control |
| 3 | lock |
| 4 | current temperature |

Top module: `thermal_trip_regs`

## Requirements
- R1: After reset, address 0 reads 125 (0x7D), address 1 reads 0, address 2 reads 0, address 3 reads 0, address 4 reads the sampled temperature, and shutdown_req is 0.
- R2: While unlocked, a write to address 0 stores wdata[7:0] as the threshold. Bits [31:8] of address 0 always read as zero.
- R3: While unlocked, a write to address 1 stores all 32 bits of the slope, and a read returns them unchanged.
- R4: The shutdown-enable control is bit 1 of address 2. While unlocked, a write stores wdata[1]. All other bits of address 2 read as zero.
- R5: The lock is bit 0 of address 3, and all other bits read as zero. Writing a 1 to bit 0 sets the lock. Writing 0 never clears it. Only bus_rst_n low clears it.
- R6: While the lock is set, writes to addresses 0, 1 and 2 leave the threshold, the slope and the shutdown enable unchanged, and the shutdown behaviour is unaffected.
- R7: Address 4 is read-only. It returns, in bits [7:0], the temperature sampled at the previous clock, and zero in bits [31:8]. Writes to it have no effect.
- R8: shutdown_req is 1 exactly when the enable is set and the sampled temperature is greater than or equal to the threshold. It responds two clocks after a change of temp_in.
- R9: Addresses 5 to 7 read as zero, and writes to them change no register.
- R10: A hardware reset after the lock was set restores all reset values, and the registers become writable again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| bus_rst_n | input | 1 | Asynchronous active-low hardware reset, released synchronously inside |
| bus_wr | input | 1 | Write strobe, one write per cycle |
| bus_rd | input | 1 | Read strobe; data appears on bus_rdata after the next clock edge |
| bus_addr | input | 3 | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, held until the next read |
| temp_in | input | 8 | Converted current temperature in degrees Celsius |
| shutdown_req | output | 1 | Thermal shutdown request |

## Verification
The bench targets the lock's edge cases: writing zero or only upper bits to the lock register, then attempts after locking to lower the threshold, change the slope and clear the enable. A lock that could be cleared or bypassed would show changed readback or a dropped shutdown request. It probes the comparison at threshold minus one, exactly at the threshold and at a threshold of zero. An off-by-one in the compare would miss the trip at equality. Reserved bits, the read-only temperature register and unmapped addresses are written with all ones, so a sloppy decode would leak the stray bits back into reads.

// File: rtl/thermal_trip_pkg.sv
package thermal_trip_pkg;
  localparam int unsigned ADDR_W = 3;

  localparam logic [ADDR_W-1:0] ADDR_LIMIT = 3'd0;
  localparam logic [ADDR_W-1:0] ADDR_SLOPE = 3'd1;
  localparam logic [ADDR_W-1:0] ADDR_SDCTL = 3'd2;
  localparam logic [ADDR_W-1:0] ADDR_LOCK  = 3'd3;
  localparam logic [ADDR_W-1:0] ADDR_TEMP  = 3'd4;

  localparam int unsigned SD_EN_BIT = 1;
  localparam int unsigned LOCK_BIT  = 0;
endpackage

// File: rtl/tt_rst_sync.sv
module tt_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= sync_d;
  end

  assign srst_n = sync_q[STAGES-1];
endmodule

// File: rtl/tt_lock.sv
module tt_lock
  import thermal_trip_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wbit_i,
  output logic              lock_o
);
  logic lock_q;
  logic lock_d;
  logic lock_en;

  // Set-only: no path back to zero except reset.
  always_comb begin
    lock_en = wr_i && (addr_i == ADDR_LOCK) && wbit_i;
    lock_d  = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       lock_q <= 1'b0;
    else if (lock_en) lock_q <= lock_d;
  end

  assign lock_o = lock_q;

  // R5: once set, the lock never drops while out of reset
  a_r5_lock_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    lock_q |=> lock_q);

  // R5: a write of 1 to bit 0 of the lock register sets it
  a_r5_lock_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && addr_i == ADDR_LOCK && wbit_i) |=> lock_o);
endmodule

// File: rtl/tt_cfg_regs.sv
module tt_cfg_regs
  import thermal_trip_pkg::*;
#(
  parameter int unsigned        DATA_W    = 32,
  parameter int unsigned        TEMP_W    = 8,
  parameter logic [TEMP_W-1:0]  LIMIT_RST = 8'd125
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lock_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [TEMP_W-1:0] limit_o,
  output logic [DATA_W-1:0] slope_o,
  output logic              sd_en_o
);
  logic [TEMP_W-1:0] limit_q, limit_d;
  logic [DATA_W-1:0] slope_q, slope_d;
  logic              sd_en_q, sd_en_d;
  logic              limit_en, slope_en, sd_en_en;
  logic              wr_ok;

  // One lock gates every field that shapes the thermal response.
  always_comb begin
    wr_ok    = wr_i && !lock_i;
    limit_en = wr_ok && (addr_i == ADDR_LIMIT);
    slope_en = wr_ok && (addr_i == ADDR_SLOPE);
    sd_en_en = wr_ok && (addr_i == ADDR_SDCTL);
    limit_d  = wdata_i[TEMP_W-1:0];
    slope_d  = wdata_i;
    sd_en_d  = wdata_i[SD_EN_BIT];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      limit_q <= LIMIT_RST;
      slope_q <= '0;
      sd_en_q <= 1'b0;
    end else begin
      if (limit_en) limit_q <= limit_d;
      if (slope_en) slope_q <= slope_d;
      if (sd_en_en) sd_en_q <= sd_en_d;
    end
  end

  assign limit_o = limit_q;
  assign slope_o = slope_q;
  assign sd_en_o = sd_en_q;

  // R6: locked configuration does not move
  a_r6_limit_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    lock_i |=> $stable(limit_q));
  a_r6_slope_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    lock_i |=> $stable(slope_q));
  a_r6_enable_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    lock_i |=> $stable(sd_en_q));
endmodule

// File: rtl/tt_trip.sv
module tt_trip #(
  parameter int unsigned TEMP_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [TEMP_W-1:0] temp_in,
  input  logic [TEMP_W-1:0] limit_i,
  input  logic              en_i,
  output logic [TEMP_W-1:0] temp_o,
  output logic              trip_o
);
  logic [TEMP_W-1:0] temp_q, temp_d;
  logic              trip_q, trip_d;

  always_comb begin
    temp_d = temp_in;
    trip_d = en_i && (temp_q >= limit_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      temp_q <= '0;
      trip_q <= 1'b0;
    end else begin
      temp_q <= temp_d;
      trip_q <= trip_d;
    end
  end

  assign temp_o = temp_q;
  assign trip_o = trip_q;

  // R8: no request one cycle after the enable is low
  a_r8_quiet_when_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> !trip_o);

  // R8: no request while the sample sits below the threshold
  a_r8_quiet_below_limit: assert property (@(posedge clk) disable iff (!rst_n)
    (temp_o < limit_i) |=> !trip_o);
endmodule

// File: rtl/thermal_trip_regs.sv
module thermal_trip_regs
  import thermal_trip_pkg::*;
#(
  parameter int unsigned       DATA_W     = 32,
  parameter int unsigned       TEMP_W     = 8,
  parameter logic [TEMP_W-1:0] LIMIT_RST  = 8'd125,
  parameter int unsigned       RST_STAGES = 2
) (
  input  logic              clk,
  input  logic              bus_rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [TEMP_W-1:0] temp_in,
  output logic              shutdown_req
);
  logic              rst_n;
  logic              lock;
  logic [TEMP_W-1:0] limit;
  logic [DATA_W-1:0] slope;
  logic              sd_en;
  logic [TEMP_W-1:0] temp_s;
  logic [DATA_W-1:0] rdata_d, rdata_q;

  tt_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk(clk), .arst_n(bus_rst_n), .srst_n(rst_n));

  tt_lock u_lock (
    .clk(clk), .rst_n(rst_n), .wr_i(bus_wr), .addr_i(bus_addr),
    .wbit_i(bus_wdata[LOCK_BIT]), .lock_o(lock));

  tt_cfg_regs #(.DATA_W(DATA_W), .TEMP_W(TEMP_W), .LIMIT_RST(LIMIT_RST)) u_cfg (
    .clk(clk), .rst_n(rst_n), .lock_i(lock), .wr_i(bus_wr), .addr_i(bus_addr),
    .wdata_i(bus_wdata), .limit_o(limit), .slope_o(slope), .sd_en_o(sd_en));

  tt_trip #(.TEMP_W(TEMP_W)) u_trip (
    .clk(clk), .rst_n(rst_n), .temp_in(temp_in), .limit_i(limit),
    .en_i(sd_en), .temp_o(temp_s), .trip_o(shutdown_req));

  always_comb begin
    rdata_d = '0;
    case (bus_addr)
      ADDR_LIMIT: rdata_d[TEMP_W-1:0] = limit;
      ADDR_SLOPE: rdata_d             = slope;
      ADDR_SDCTL: rdata_d[SD_EN_BIT]  = sd_en;
      ADDR_LOCK:  rdata_d[LOCK_BIT]   = lock;
      ADDR_TEMP:  rdata_d[TEMP_W-1:0] = temp_s;
      default:    rdata_d             = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rdata_q <= '0;
    else if (bus_rd) rdata_q <= rdata_d;
  end

  assign bus_rdata = rdata_q;

  // R2: threshold upper bits always read back as zero
  a_r2_limit_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == ADDR_LIMIT) |=> (bus_rdata[DATA_W-1:TEMP_W] == '0));

  // R9: unmapped addresses read as zero
  a_r9_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr > ADDR_TEMP) |=> (bus_rdata == '0));

  // R5: lock register shows the lock in bit 0 only
  a_r5_lock_readback: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == ADDR_LOCK) |=> (bus_rdata[DATA_W-1:1] == '0));
endmodule

// File: tb/tb_thermal_trip_regs.sv
module tb_thermal_trip_regs;
  typedef struct {
    logic [31:0] exp;
    string       tag;
  } rd_item_t;

  logic        clk = 1'b0;
  logic        bus_rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [7:0]  temp_in = '0;
  logic        shutdown_req;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  rd_item_t sb[$];

  always #5 clk = ~clk;

  thermal_trip_regs dut (
    .clk(clk), .bus_rst_n(bus_rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .temp_in(temp_in), .shutdown_req(shutdown_req));

  // Monitor: the read strobe seen at this falling edge was captured at the
  // rising edge just before, so bus_rdata holds its result now.
  initial begin
    forever begin
      @(negedge clk);
      if (bus_rd) begin
        rd_item_t it;
        checks++;
        if (sb.size() == 0) begin
          fails++;
          $display("FAIL %s: read with empty scoreboard, got %h", "monitor", bus_rdata);
        end else begin
          it = sb.pop_front();
          if (bus_rdata !== it.exp) begin
            fails++;
            $display("FAIL %s: rdata=%h expected=%h", it.tag, bus_rdata, it.exp);
          end
        end
      end
    end
  end

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); #1;
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); #1;
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, input logic [31:0] e, input string tag);
    rd_item_t it;
    @(negedge clk); #1;
    it.exp = e; it.tag = tag;
    sb.push_back(it);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk); #1;
    bus_rd = 1'b0;
  endtask

  task automatic settle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic chk_sd(input logic e, input string tag);
    settle(3);
    checks++;
    if (shutdown_req !== e) begin
      fails++;
      $display("FAIL %s: shutdown_req=%b expected=%b", tag, shutdown_req, e);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    bus_rst_n = 1'b0;
    settle(3);
    bus_rst_n = 1'b1;
    settle(4);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: run did not finish, got timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    temp_in = 8'h00;
    do_reset();

    // R1 reset state
    rd(3'd0, 32'h0000_007D, "R1 limit");
    rd(3'd1, 32'h0, "R1 slope");
    rd(3'd2, 32'h0, "R1 sdctl");
    rd(3'd3, 32'h0, "R1 lock");
    rd(3'd4, 32'h0, "R1 temp");
    chk_sd(1'b0, "R1 shutdown");

    // R2 threshold field
    wr(3'd0, 32'hFFFF_FF50);
    rd(3'd0, 32'h0000_0050, "R2 limit write");
    // R3 slope
    wr(3'd1, 32'hDEAD_BEEF);
    rd(3'd1, 32'hDEAD_BEEF, "R3 slope write");
    wr(3'd1, 32'h8000_0001);
    rd(3'd1, 32'h8000_0001, "R3 slope rewrite");
    // R4 enable bit position
    wr(3'd2, 32'hFFFF_FFFD);
    rd(3'd2, 32'h0, "R4 sdctl bit1 clear");
    wr(3'd2, 32'hFFFF_FFFF);
    rd(3'd2, 32'h0000_0002, "R4 sdctl bit1 set");

    // R7 read-only temperature
    temp_in = 8'h33;
    settle(2);
    wr(3'd4, 32'hFFFF_FF77);
    rd(3'd4, 32'h0000_0033, "R7 temp readonly");

    // R9 unmapped
    wr(3'd5, 32'hFFFF_FFFF);
    wr(3'd7, 32'hFFFF_FFFF);
    rd(3'd5, 32'h0, "R9 addr5");
    rd(3'd7, 32'h0, "R9 addr7");
    rd(3'd0, 32'h0000_0050, "R9 limit untouched");
    rd(3'd3, 32'h0, "R9 lock untouched");

    // R8 compare, threshold 0x50, enable on
    temp_in = 8'h4F; chk_sd(1'b0, "R8 below limit");
    temp_in = 8'h50; chk_sd(1'b1, "R8 at limit");
    temp_in = 8'hFF; chk_sd(1'b1, "R8 max temp");
    wr(3'd2, 32'h0);
    chk_sd(1'b0, "R8 disabled");
    wr(3'd2, 32'h2);
    wr(3'd0, 32'h0);
    temp_in = 8'h00; chk_sd(1'b1, "R8 zero limit");
    // R8 latency: temp change shows after two clocks
    wr(3'd0, 32'h80);
    temp_in = 8'h10;
    settle(3);
    @(negedge clk); #1 temp_in = 8'h90;
    @(negedge clk);
    checks++;
    if (shutdown_req !== 1'b0) begin
      fails++; $display("FAIL R8 latency one clock: got %b expected 0", shutdown_req);
    end
    @(negedge clk);
    checks++;
    if (shutdown_req !== 1'b1) begin
      fails++; $display("FAIL R8 latency two clocks: got %b expected 1", shutdown_req);
    end

    // Program final config, then lock (R5)
    wr(3'd0, 32'h60);
    wr(3'd1, 32'h1234_5678);
    wr(3'd2, 32'h2);
    wr(3'd3, 32'h0);
    rd(3'd3, 32'h0, "R5 write zero no lock");
    wr(3'd3, 32'hFFFF_FFFE);
    rd(3'd3, 32'h0, "R5 upper bits no lock");
    wr(3'd3, 32'h1);
    rd(3'd3, 32'h1, "R5 lock set");
    wr(3'd3, 32'h0);
    rd(3'd3, 32'h1, "R5 lock not cleared");

    // R6 locked writes ignored
    wr(3'd0, 32'hFF);
    wr(3'd1, 32'h0);
    wr(3'd2, 32'h0);
    rd(3'd0, 32'h0000_0060, "R6 limit held");
    rd(3'd1, 32'h1234_5678, "R6 slope held");
    rd(3'd2, 32'h0000_0002, "R6 enable held");
    temp_in = 8'h70; chk_sd(1'b1, "R6 trip survives disable attempt");
    temp_in = 8'h5F; chk_sd(1'b0, "R6 locked limit still compares");

    // R10 reset clears lock
    do_reset();
    rd(3'd3, 32'h0, "R10 lock cleared");
    rd(3'd0, 32'h0000_007D, "R10 limit reset");
    rd(3'd2, 32'h0, "R10 enable reset");
    wr(3'd0, 32'h42);
    rd(3'd0, 32'h0000_0042, "R10 writable again");

    settle(3);
    checks++;
    if (sb.size() != 0) begin
      fails++;
      $display("FAIL scoreboard: %0d items left expected 0", sb.size());
    end
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule